// File: doc/BRIEF.md
# Pseudo-SRAM Power-Mode Sequencer

This block owns the two chip-enable pins of a pseudo-static memory across every change of power mode. It holds the high-true enable low while the supply settles. It then raises it with the low-true enable parked high and waits out the memory's long wake-up interval. Only after that does it raise a ready flag, which lets the access controller drive the low-true enable.

When the system asks for power-down, the request is latched. It is honoured only once the access controller reports that it is idle. A short guard interval with the low-true enable held high comes before the high-true enable is dropped. The power-down state lasts a minimum time before it can be left again, and every exit goes through the same wake-up wait. In power-down the memory does not keep its contents, so the user must reload anything it needs after wake-up.

All intervals are given in nanoseconds and converted to clock cycles from a clock-period parameter, rounding up. If the supply flag is lost in any state, the sequence returns to its reset state on the next clock edge.

Top module: `psram_pwr_seq`

States: reset (RST), power-up wait (PWRUP), wake wait (WAKE), active (ACTIVE), power-down entry guard (GUARD), power-down (PDOWN), exit (EXIT). Transitions:
- RST→PWRUP when the supply flag is high.
- PWRUP→WAKE when the power-up interval expires.
- WAKE→ACTIVE when the wake interval expires.
- ACTIVE→GUARD when a request is pending and the controller is idle.
- GUARD→PDOWN when the guard interval expires.
- PDOWN→EXIT when the minimum interval has expired and the request is low.
- EXIT→WAKE always.
- Any state→RST when the supply flag is low.

## Requirements
- R1: While reset is asserted or supply_ok is low, mem_ce2=0, mem_ce1_n=1 and mem_ready=0. Dropping supply_ok in any state brings these values back on the next rising edge.
- R2: mem_ce2 first goes high on the (PWRUP_CYC+1)-th rising edge after supply_ok is first sampled high, where PWRUP_CYC is the cycle count for PWRUP_HOLD_NS.
- R3: At power-up, mem_ready goes high exactly WAKE_CYC rising edges after the edge at which mem_ce2 rose. mem_ce1_n stays 1 throughout, whatever the value of acc_ce1_n.
- R4: mem_ready is 1 only in the active state. Whenever mem_ready=0, mem_ce1_n=1. Whenever mem_ready=1, mem_ce1_n follows acc_ce1_n in the same cycle.
- R5: A pdn_req seen high while active is held pending even if pdn_req later drops. If acc_idle is already 1, mem_ready falls on the second edge after pdn_req is first sampled high. If acc_idle is 0, mem_ready stays 1, and it falls on the first edge after acc_idle is sampled 1.
- R6: pdn_req pulses while mem_ready=0 are ignored. They do not cause a power-down after mem_ready rises.
- R7: mem_ce2 falls exactly GUARD_CYC edges after mem_ready falls, and mem_ce1_n stays 1 over that interval. GUARD_CYC is the cycle count of the larger of CE1_SETUP_NS and QUIET_NS.
- R8: mem_ce2 stays low for at least PDN_MIN_CYC cycles. If pdn_req is already low, it rises after exactly PDN_MIN_CYC edges. Otherwise it rises on the first edge after pdn_req is sampled low.
- R9: On power-down exit, mem_ce2 rises while mem_ce1_n=1, and mem_ready rises WAKE_CYC+1 edges after that rise.
- R10: Each interval in cycles is ceil(ns*1000/CLK_PERIOD_PS), and never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply has reached its operating level |
| pdn_req | input | 1 | Power-down request; high means stay powered down |
| acc_idle | input | 1 | Access controller is in a quiet standby |
| acc_ce1_n | input | 1 | Low-true enable wanted by the access controller |
| mem_ce2 | output | 1 | High-true chip enable to the memory |
| mem_ce1_n | output | 1 | Low-true chip enable to the memory |
| mem_ready | output | 1 | Accesses are allowed |

## Verification
Each interval state lasts exactly its computed cycle count, and every transition is registered. The measured latencies are therefore:
- supply flag to CE2 rise: PWRUP_CYC+1 edges;
- CE2 rise to ready: WAKE_CYC edges, or WAKE_CYC+1 after a power-down exit;
- request to ready fall: two edges, or one edge after idle arrives;
- ready fall to CE2 fall: GUARD_CYC edges;
- CE2 fall to rise: PDN_MIN_CYC edges, or one edge after a late withdrawal.

The bench drives inputs at the falling edge and then counts rising edges until it sees the awaited level at the next falling edge. It compares that count with the value it derives from the nanosecond parameters, so each result is sampled half a cycle after the edge that produces it. The enable pass-through is combinational and is checked one time step after each drive.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_RESET  = 3'd0,
        PS_PWRUP  = 3'd1,
        PS_WAKE   = 3'd2,
        PS_ACTIVE = 3'd3,
        PS_GUARD  = 3'd4,
        PS_PDOWN  = 3'd5,
        PS_EXIT   = 3'd6
    } pwr_state_t;

    // R10: round an interval in ns up to whole clock cycles, at least one
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        longint unsigned num;
        longint unsigned cyc;
        num = longint'(ns) * 64'd1000;
        cyc = (num + longint'(period_ps) - 64'd1) / longint'(period_ps);
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc);
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_interval_timer.sv
module pwr_interval_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // loaded with N-1 on state entry, so the state lasts N cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pdn_request_latch.sv
module pdn_request_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic arm,
    output logic pending
);

    logic pend_q;

    // captured only while armed (active); dropped whenever not armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!arm) begin
            pend_q <= 1'b0;
        end else if (req) begin
            pend_q <= 1'b1;
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import psram_pwr_pkg::*;
#(
    parameter int unsigned PWRUP_CYC   = 6250,
    parameter int unsigned WAKE_CYC    = 43750,
    parameter int unsigned GUARD_CYC   = 3,
    parameter int unsigned PDN_MIN_CYC = 13,
    parameter int unsigned CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             pdn_req,
    input  logic             pdn_pending,
    input  logic             acc_idle,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ce2,
    output logic             ce1_hold,
    output logic             ready
);

    localparam logic [CNT_W-1:0] PWRUP_LD = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] GUARD_LD = CNT_W'(GUARD_CYC - 1);
    localparam logic [CNT_W-1:0] PDN_LD   = CNT_W'(PDN_MIN_CYC - 1);

    pwr_state_t state_q;
    pwr_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RESET;
        end else begin
            state_q <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PS_RESET:  if (supply_ok) state_nx = PS_PWRUP;
            PS_PWRUP:  if (tmr_done) state_nx = PS_WAKE;
            PS_WAKE:   if (tmr_done) state_nx = PS_ACTIVE;
            PS_ACTIVE: if (pdn_pending && acc_idle) state_nx = PS_GUARD;
            PS_GUARD:  if (tmr_done) state_nx = PS_PDOWN;
            PS_PDOWN:  if (tmr_done && !pdn_req) state_nx = PS_EXIT;
            PS_EXIT:   state_nx = PS_WAKE;
            default:   state_nx = PS_RESET;
        endcase
        if (!supply_ok) state_nx = PS_RESET;
    end

    // interval load on every state change
    always_comb begin
        tmr_load = (state_nx != state_q);
        tmr_val  = '0;
        unique case (state_nx)
            PS_PWRUP: tmr_val = PWRUP_LD;
            PS_WAKE:  tmr_val = WAKE_LD;
            PS_GUARD: tmr_val = GUARD_LD;
            PS_PDOWN: tmr_val = PDN_LD;
            default:  tmr_val = '0;
        endcase
    end

    // Moore outputs
    always_comb begin
        ce2      = 1'b1;
        ce1_hold = 1'b1;
        ready    = 1'b0;
        unique case (state_q)
            PS_RESET, PS_PWRUP, PS_PDOWN: ce2 = 1'b0;
            PS_ACTIVE: begin
                ce1_hold = 1'b0;
                ready    = 1'b1;
            end
            default: ce2 = 1'b1;
        endcase
    end

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned PWRUP_HOLD_NS = 50000,
    parameter int unsigned WAKE_HOLD_NS  = 350000,
    parameter int unsigned CE1_SETUP_NS  = 10,
    parameter int unsigned QUIET_NS      = 20,
    parameter int unsigned PDN_MIN_NS    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic pdn_req,
    input  logic acc_idle,
    input  logic acc_ce1_n,
    output logic mem_ce2,
    output logic mem_ce1_n,
    output logic mem_ready
);

    localparam int unsigned PWRUP_CYC   = ns_to_cycles(PWRUP_HOLD_NS, CLK_PERIOD_PS);
    localparam int unsigned WAKE_CYC    = ns_to_cycles(WAKE_HOLD_NS, CLK_PERIOD_PS);
    localparam int unsigned GUARD_CYC   = ns_to_cycles(max_of(CE1_SETUP_NS, QUIET_NS), CLK_PERIOD_PS);
    localparam int unsigned PDN_MIN_CYC = ns_to_cycles(PDN_MIN_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC     = max_of(max_of(PWRUP_CYC, WAKE_CYC),
                                                 max_of(GUARD_CYC, PDN_MIN_CYC));
    localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             pdn_pending;
    logic             ce2;
    logic             ce1_hold;
    logic             ready;

    pwr_interval_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pdn_request_latch req_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pdn_req),
        .arm     (ready),
        .pending (pdn_pending)
    );

    pwr_mode_fsm #(
        .PWRUP_CYC   (PWRUP_CYC),
        .WAKE_CYC    (WAKE_CYC),
        .GUARD_CYC   (GUARD_CYC),
        .PDN_MIN_CYC (PDN_MIN_CYC),
        .CNT_W       (CNT_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .pdn_req     (pdn_req),
        .pdn_pending (pdn_pending),
        .acc_idle    (acc_idle),
        .tmr_done    (tmr_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ce2         (ce2),
        .ce1_hold    (ce1_hold),
        .ready       (ready)
    );

    assign mem_ce2   = ce2;
    assign mem_ce1_n = ce1_hold | acc_ce1_n;
    assign mem_ready = ready;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk
    import psram_pwr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned PWRUP_HOLD_NS = 50000,
    parameter int unsigned WAKE_HOLD_NS  = 350000,
    parameter int unsigned CE1_SETUP_NS  = 10,
    parameter int unsigned QUIET_NS      = 20,
    parameter int unsigned PDN_MIN_NS    = 100
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic acc_idle,
    input logic mem_ce2,
    input logic mem_ce1_n,
    input logic mem_ready
);

    localparam int unsigned PWRUP_CYC   = ns_to_cycles(PWRUP_HOLD_NS, CLK_PERIOD_PS);
    localparam int unsigned WAKE_CYC    = ns_to_cycles(WAKE_HOLD_NS, CLK_PERIOD_PS);
    localparam int unsigned GUARD_CYC   = ns_to_cycles(max_of(CE1_SETUP_NS, QUIET_NS), CLK_PERIOD_PS);
    localparam int unsigned PDN_MIN_CYC = ns_to_cycles(PDN_MIN_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC     = max_of(max_of(PWRUP_CYC, WAKE_CYC),
                                                 max_of(GUARD_CYC, PDN_MIN_CYC));
    localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WAKE_LIM  = CNT_W'(WAKE_CYC);
    localparam logic [CNT_W-1:0] GUARD_LIM = CNT_W'(GUARD_CYC);
    localparam logic [CNT_W-1:0] PDN_LIM   = CNT_W'(PDN_MIN_CYC);

    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] wk_cnt;
    logic [CNT_W-1:0] gd_cnt;

    // consecutive cycles with CE2 low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lo_cnt <= '0;
        else if (mem_ce2) lo_cnt <= '0;
        else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
    end

    // cycles with CE2 high and accesses not yet allowed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_cnt <= '0;
        else if (!mem_ce2 || mem_ready) wk_cnt <= '0;
        else if (wk_cnt != '1) wk_cnt <= wk_cnt + 1'b1;
    end

    // cycles with CE2 high, CE1 parked high, not ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gd_cnt <= '0;
        else if (!mem_ce2 || mem_ready || !mem_ce1_n) gd_cnt <= '0;
        else if (gd_cnt != '1) gd_cnt <= gd_cnt + 1'b1;
    end

    a_r1_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!mem_ce2 && mem_ce1_n && !mem_ready));

    a_r3_wake_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready) |-> (wk_cnt >= WAKE_LIM));

    a_r4_ce1_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> mem_ce1_n);

    a_r4_ready_needs_ce2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> mem_ce2);

    a_r5_entry_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ready) && supply_ok && $past(supply_ok)) |-> $past(acc_idle));

    a_r7_guard_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce2) && supply_ok && $past(supply_ok)) |-> (gd_cnt >= GUARD_LIM));

    a_r8_min_down: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce2) |-> (lo_cnt >= PDN_LIM));

    a_r9_rise_ce1_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce2) |-> (mem_ce1_n && $past(mem_ce1_n)));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .PWRUP_HOLD_NS (PWRUP_HOLD_NS),
    .WAKE_HOLD_NS  (WAKE_HOLD_NS),
    .CE1_SETUP_NS  (CE1_SETUP_NS),
    .QUIET_NS      (QUIET_NS),
    .PDN_MIN_NS    (PDN_MIN_NS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .acc_idle  (acc_idle),
    .mem_ce2   (mem_ce2),
    .mem_ce1_n (mem_ce1_n),
    .mem_ready (mem_ready)
);

// File: tb/psram_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module psram_pwr_seq_tb_top;

    localparam int P_PS    = 8000;
    localparam int PWR_NS  = 400;
    localparam int WAKE_NS = 800;
    localparam int SET_NS  = 10;
    localparam int QUI_NS  = 20;
    localparam int PDN_NS  = 100;

    // R10: expected interval lengths, derived here from the ns values
    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + P_PS - 1) / P_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_PWR  = (PWR_NS * 1000 + P_PS - 1) / P_PS;
    localparam int E_WAKE = (WAKE_NS * 1000 + P_PS - 1) / P_PS;

    logic clk = 1'b0;
    logic rst_n, supply_ok, pdn_req, acc_idle, acc_ce1_n;
    logic mem_ce2, mem_ce1_n, mem_ready;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    psram_pwr_seq #(
        .CLK_PERIOD_PS (P_PS),
        .PWRUP_HOLD_NS (PWR_NS),
        .WAKE_HOLD_NS  (WAKE_NS),
        .CE1_SETUP_NS  (SET_NS),
        .QUIET_NS      (QUI_NS),
        .PDN_MIN_NS    (PDN_NS)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pdn_req   (pdn_req),
        .acc_idle  (acc_idle),
        .acc_ce1_n (acc_ce1_n),
        .mem_ce2   (mem_ce2),
        .mem_ce1_n (mem_ce1_n),
        .mem_ready (mem_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic pick(input int which);
        case (which)
            0: return mem_ce2;
            1: return mem_ready;
            default: return mem_ce1_n;
        endcase
    endfunction

    // count rising edges until the chosen output shows the level
    task automatic wait_for(input int which, input logic lvl, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (pick(which) !== lvl && n < 1000);
    endtask

    task automatic check_parked(input string req);
        chk({req, " ce2"}, int'(mem_ce2), 0);
        chk({req, " ce1_n"}, int'(mem_ce1_n), 1);
        chk({req, " ready"}, int'(mem_ready), 0);
    endtask

    task automatic power_up();
        int n;
        int n2;
        bit ce1_ok;
        acc_ce1_n = 1'b0;
        supply_ok = 1'b1;
        wait_for(0, 1'b1, n);
        chk("R2 supply to ce2 rise", n, cyc(PWR_NS) + 1);
        chk("R3 ce1_n at ce2 rise", int'(mem_ce1_n), 1);
        // R6: request pulse during wake wait
        pdn_req = 1'b1;
        step();
        pdn_req = 1'b0;
        ce1_ok = (mem_ce1_n === 1'b1);
        wait_for(1, 1'b1, n2);
        chk("R3 ce2 rise to ready", n2 + 1, E_WAKE);
        chk("R4 ce1_n parked in wake", int'(ce1_ok), 1);
        acc_ce1_n = 1'b1;
        acc_idle = 1'b1;
        repeat (10) step();
        chk("R6 ignored request", int'(mem_ready), 1);
    endtask

    task automatic passthrough(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            acc_ce1_n = 1'($urandom_range(0, 1));
            #1;
            chk("R4 ce1 pass-through", int'(mem_ce1_n), int'(acc_ce1_n));
            step();
        end
        acc_ce1_n = 1'b1;
    endtask

    task automatic power_down(input int idle_delay, input int hold_extra);
        int n;
        acc_ce1_n = 1'b1;
        acc_idle = (idle_delay == 0);
        pdn_req = 1'b1;
        if (idle_delay == 0) begin
            wait_for(1, 1'b0, n);
            chk("R5 request to ready fall", n, 2);
        end else begin
            step();
            pdn_req = 1'b0;
            for (int i = 1; i < idle_delay + 1; i++) step();
            chk("R5 pending while busy", int'(mem_ready), 1);
            acc_idle = 1'b1;
            wait_for(1, 1'b0, n);
            chk("R5 idle to ready fall", n, 1);
        end
        pdn_req = (hold_extra > 0);
        wait_for(0, 1'b0, n);
        chk("R7 guard length", n, cyc(QUI_NS > SET_NS ? QUI_NS : SET_NS));
        if (hold_extra == 0) begin
            wait_for(0, 1'b1, n);
            chk("R8 R10 min power-down", n, cyc(PDN_NS));
        end else begin
            repeat (cyc(PDN_NS) + hold_extra) step();
            chk("R8 held down", int'(mem_ce2), 0);
            pdn_req = 1'b0;
            wait_for(0, 1'b1, n);
            chk("R8 exit after withdrawal", n, 1);
        end
        chk("R9 ce1_n at exit", int'(mem_ce1_n), 1);
        wait_for(1, 1'b1, n);
        chk("R9 exit to ready", n, E_WAKE + 1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C2E));
        rst_n = 1'b0;
        supply_ok = 1'b0;
        pdn_req = 1'b0;
        acc_idle = 1'b1;
        acc_ce1_n = 1'b0;
        repeat (3) step();
        check_parked("R1 in reset");
        rst_n = 1'b1;
        repeat (5) step();
        check_parked("R1 no supply");

        power_up();
        passthrough(20);
        power_down(0, 0);
        passthrough(8);
        power_down(4, 0);
        power_down(0, 5);

        // R1: supply loss from active, then from power-down
        acc_ce1_n = 1'b0;
        supply_ok = 1'b0;
        step();
        check_parked("R1 loss in active");
        repeat (4) step();
        power_up();
        acc_idle = 1'b1;
        pdn_req = 1'b1;
        repeat (6) step();
        chk("R5 in power-down", int'(mem_ce2), 0);
        supply_ok = 1'b0;
        pdn_req = 1'b0;
        step();
        check_parked("R1 loss in power-down");
        repeat (3) step();
        power_up();

        for (int k = 0; k < 6; k++) begin
            passthrough(int'($urandom_range(2, 10)));
            power_down(int'($urandom_range(0, 6)),
                       ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 9)) : 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule